// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits. It takes one recoded multiplier bit per clock and returns a signed product of `2*WIDTH` bits. Each step looks at the current low bit of the multiplier register and at the bit that was shifted out of it on the step before. From that pair it chooses one of three actions on the upper accumulator: leave it unchanged, subtract the multiplicand, or add the multiplicand. The whole accumulator/multiplier register then shifts one place to the right, and the shift keeps the sign. A run of ones in the multiplier therefore costs one subtraction where the run starts and one addition after it ends, and no arithmetic is done inside the run.

A one-cycle `start` strobe loads the operands while the block is idle. The block then takes exactly `WIDTH` steps, raises `done` and holds the product until the next start. A counter reports how many add or subtract operations the last multiplication needed. A generate parameter can leave this counter out. A second parameter chooses between a single shared adder with a carry-in for subtraction and separate add and subtract paths with a result mux.

Top module: `booth_seq_mult`

## Requirements
- R1: During and right after reset, `busy`, `done`, `product` and `op_count` are all zero.
- R2: A `start` sampled high while `busy` is low loads `x` and `y`, clears the operation count, and sets `busy` with `done` low from the next cycle on.
- R3: A run takes exactly `WIDTH` steps. `busy` and `done` are never high together, and `done` rises `WIDTH` clock edges after the edge that accepted `start`.
- R4: When `done` is high, `product` equals the signed product of the accepted `x` and `y` in `2*WIDTH` bits. This includes operands at the most negative value.
- R5: A step whose bit pair (current multiplier bit, previous bit) is equal does no arithmetic and leaves `op_count` unchanged.
- R6: A pair of 1,0 subtracts `x` and a pair of 0,1 adds `x`. The previous bit of the first step is 0. So `op_count` equals the number of positions i in 0..WIDTH-1 where y[i] differs from y[i-1], taking y[-1] = 0. A single run of ones that does not reach the MSB costs exactly 2.
- R7: A multiplier of alternating bits starting with 1 at bit 0 (0x55 for 8 bits) needs an operation on every step, so `op_count` equals `WIDTH`. `op_count` never exceeds `WIDTH`.
- R8: A `start` that arrives while `busy` is high is ignored. The running product still uses the operands accepted first.
- R9: While idle with `start` low, `product`, `done` and `op_count` hold their values whatever `x` and `y` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe that begins a multiplication when idle |
| x | input | WIDTH | Signed multiplicand |
| y | input | WIDTH | Signed multiplier |
| product | output | 2*WIDTH | Signed product, valid while `done` is high |
| done | output | 1 | High from the end of a run until the next accepted start |
| busy | output | 1 | High while steps are in progress |
| op_count | output | $clog2(WIDTH+1) | Add/subtract operations used by the latest run |

## Verification
The assertions assume that `start` is a one-cycle pulse. They also assume that `x` and `y` matter only on the accepting edge, so the register copies, not the ports, must stay stable during a run. The stimulus drives `start` for exactly one cycle at a falling edge. It changes `x` and `y` freely while the block runs or idles, and it pulses `start` once in the middle of a run to show the pulse is ignored. Random operand pairs come from a fixed seed. Directed cases add the most negative value, zero, all ones, alternating bits and a single run of ones, which sit at the edges of the arithmetic and of the operation count.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic [1:0] {
      BOOTH_HOLD = 2'd0,
      BOOTH_SUB  = 2'd1,
      BOOTH_ADD  = 2'd2
   } booth_op_e;

   function automatic booth_op_e booth_decode(input logic cur_bit, input logic prev_bit);
      booth_op_e op;
      case ({cur_bit, prev_bit})
         2'b10:   op = BOOTH_SUB;
         2'b01:   op = BOOTH_ADD;
         default: op = BOOTH_HOLD;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);

   always_comb begin
      op = booth_decode(cur_bit, prev_bit);
   end

endmodule

// File: rtl/booth_accum_path.sv
module booth_accum_path
   import booth_pkg::*;
#(
   parameter int  WIDTH        = 8,
   parameter bit  SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH:0]   acc_in,
   input  logic [WIDTH-1:0] mcand,
   input  booth_op_e        op,
   output logic [WIDTH:0]   acc_out
);

   localparam int AW = WIDTH + 1;

   logic [AW-1:0] mcand_ext;

   assign mcand_ext = {mcand[WIDTH-1], mcand};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [AW-1:0] operand;
         logic          carry_in;
         always_comb begin
            case (op)
               BOOTH_SUB: begin
                  operand  = ~mcand_ext;
                  carry_in = 1'b1;
               end
               BOOTH_ADD: begin
                  operand  = mcand_ext;
                  carry_in = 1'b0;
               end
               default: begin
                  operand  = '0;
                  carry_in = 1'b0;
               end
            endcase
            acc_out = acc_in + operand + AW'(carry_in);
         end
      end else begin : g_split
         logic [AW-1:0] sum_path;
         logic [AW-1:0] diff_path;
         assign sum_path  = acc_in + mcand_ext;
         assign diff_path = acc_in - mcand_ext;
         always_comb begin
            case (op)
               BOOTH_SUB: acc_out = diff_path;
               BOOTH_ADD: acc_out = sum_path;
               default:   acc_out = acc_in;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_op_counter.sv
module booth_op_counter #(
   parameter int MAX_OPS = 8,
   parameter bit ENABLE  = 1'b1,
   localparam int CW     = $clog2(MAX_OPS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   output logic [CW-1:0] count
);

   generate
      if (ENABLE) begin : g_count
         logic [CW-1:0] count_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               count_q <= '0;
            end else if (clear) begin
               count_q <= '0;
            end else if (inc) begin
               count_q <= count_q + 1'b1;
            end
         end
         assign count = count_q;

         AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && !inc) |=> $stable(count_q)); // R5
      end else begin : g_no_count
         assign count = '0;
      end
   endgenerate

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit COUNT_OPS    = 1'b1,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int PW          = 2 * WIDTH,
   localparam int CW          = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [PW-1:0]    product,
   output logic             done,
   output logic             busy,
   output logic [CW-1:0]    op_count
);

   localparam int AW = WIDTH + 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mult: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mcand_q;
   logic [AW-1:0]    acc_q;
   logic [WIDTH-1:0] mplr_q;
   logic             prev_q;
   logic [CW-1:0]    step_q;
   logic             busy_q;
   logic             done_q;
   logic [PW-1:0]    prod_q;

   booth_op_e        step_op;
   logic [AW-1:0]    acc_sum;
   logic [AW-1:0]    acc_shift;
   logic [WIDTH-1:0] mplr_shift;
   logic             last_step;
   logic             accept;

   booth_recoder u_rec (
      .cur_bit  (mplr_q[0]),
      .prev_bit (prev_q),
      .op       (step_op)
   );

   booth_accum_path #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_acc (
      .acc_in  (acc_q),
      .mcand   (mcand_q),
      .op      (step_op),
      .acc_out (acc_sum)
   );

   assign acc_shift  = {acc_sum[AW-1], acc_sum[AW-1:1]};
   assign mplr_shift = {acc_sum[0], mplr_q[WIDTH-1:1]};
   assign last_step  = (step_q == CW'(WIDTH - 1));
   assign accept     = start && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q <= '0;
         acc_q   <= '0;
         mplr_q  <= '0;
         prev_q  <= 1'b0;
         step_q  <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         prod_q  <= '0;
      end else if (accept) begin
         mcand_q <= x;
         acc_q   <= '0;
         mplr_q  <= y;
         prev_q  <= 1'b0;
         step_q  <= '0;
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
      end else if (busy_q) begin
         acc_q  <= acc_shift;
         mplr_q <= mplr_shift;
         prev_q <= mplr_q[0];
         step_q <= step_q + 1'b1;
         if (last_step) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            prod_q <= {acc_shift[WIDTH-1:0], mplr_shift};
         end
      end
   end

   booth_op_counter #(
      .MAX_OPS (WIDTH),
      .ENABLE  (COUNT_OPS)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .inc   (busy_q && (step_op != BOOTH_HOLD)),
      .count (op_count)
   );

   assign product = prod_q;
   assign done    = done_q;
   assign busy    = busy_q;

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q)); // R3
   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && start) |=> (busy_q && !done_q && step_q == '0)); // R2
   AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last_step) |=> (!busy_q && done_q)); // R3
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && !last_step) |=> (busy_q && $stable(mcand_q))); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> ($stable(prod_q) && $stable(done_q) && $stable(op_count))); // R9
   AST_EQUAL_PAIR_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (mplr_q[0] == prev_q)) |=> $stable(op_count)); // R5
   AST_OPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      op_count <= CW'(WIDTH)); // R7

endmodule

// File: tb/tb_booth_seq_mult.sv
module tb_booth_seq_mult;

   localparam int W  = 8;
   localparam int PW = 2 * W;
   localparam int CW = $clog2(W + 1);

   logic          clk;
   logic          rst_n;
   logic          start;
   logic [W-1:0]  x;
   logic [W-1:0]  y;
   logic [PW-1:0] product;
   logic          done;
   logic          busy;
   logic [CW-1:0] op_count;

   int checks;
   int failures;
   int cycles;

   booth_seq_mult #(.WIDTH(W)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .x        (x),
      .y        (y),
      .product  (product),
      .done     (done),
      .busy     (busy),
      .op_count (op_count)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<150000)", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [PW-1:0] exp_product(input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [PW-1:0] r;
      r = $signed(a) * $signed(b);
      return r;
   endfunction

   function automatic int exp_ops(input logic [W-1:0] b);
      int n;
      logic prev;
      n = 0;
      prev = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (b[i] != prev) n++;
         prev = b[i];
      end
      return n;
   endfunction

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit poke_start, input bit full_check);
      logic [PW-1:0] ep;
      int eo;
      ep = exp_product(a, b);
      eo = exp_ops(b);
      @(negedge clk);
      x = a;
      y = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      x = ~a;
      y = b ^ 8'h3C;
      if (full_check) check(busy == 1'b1 && done == 1'b0, "R2 busy after start", busy, 1);
      for (int k = 1; k < W; k++) begin
         @(negedge clk);
         if (poke_start && k == 2) start = 1'b1;
         if (poke_start && k == 3) start = 1'b0;
         if (full_check && k == W - 1)
            check(done == 1'b0 && busy == 1'b1, "R3 not done before last step", done, 0);
      end
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1 && busy == 1'b0, "R3 done after WIDTH steps", done, 1);
      check(product == ep, "R4 product", $signed(product), $signed(ep));
      check(int'(op_count) == eo, "R6 op_count", op_count, eo);
   endtask

   initial begin
      int unused_seed;
      logic [PW-1:0] held;
      logic [CW-1:0] held_ops;
      checks = 0;
      failures = 0;
      cycles = 0;
      rst_n = 1'b0;
      start = 1'b0;
      x = '0;
      y = '0;
      unused_seed = $urandom(32'h1B00_7E55);
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && product == 0 && op_count == 0, "R1 reset state", product, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && product == 0 && op_count == 0, "R1 after reset", op_count, 0);

      run_mult(8'd0, 8'd0, 1'b0, 1'b1);
      run_mult(8'h80, 8'h80, 1'b0, 1'b1);
      run_mult(8'h80, 8'h7F, 1'b0, 1'b1);
      run_mult(8'h7F, 8'h80, 1'b0, 1'b1);
      run_mult(8'd1, 8'hFF, 1'b0, 1'b1);
      // R6: single run of ones in the middle costs exactly two operations
      run_mult(8'd37, 8'b0011_1100, 1'b0, 1'b1);
      check(op_count == 2, "R6 single run costs two", op_count, 2);
      // R5: all ones and all zeros keep the count low
      run_mult(8'd99, 8'hFF, 1'b0, 1'b1);
      check(op_count == 1, "R5 equal pairs skip arithmetic", op_count, 1);
      // R7: alternating pattern needs an operation on every step
      run_mult(8'hC3, 8'h55, 1'b0, 1'b1);
      check(op_count == W, "R7 alternating worst case", op_count, W);
      // R8: start while busy is ignored
      run_mult(8'd77, 8'hA6, 1'b1, 1'b1);

      // R9: idle outputs hold while inputs change
      held = product;
      held_ops = op_count;
      for (int k = 0; k < 6; k++) begin
         x = 8'($urandom());
         y = 8'($urandom());
         @(negedge clk);
      end
      check(product == held && done == 1'b1 && op_count == held_ops, "R9 idle hold",
            product, held);

      for (int n = 0; n < 300; n++) begin
         run_mult(8'($urandom()), 8'($urandom()), (n % 17) == 5, 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule